// File: doc/BRIEF.md
# Banked Shared Scratch Memory

This block is the on-chip scratch store that the waves of one workgroup processor share. It is split into 32 banks. A request carries up to 32 lane addresses under a lane-valid mask, together with an opcode (read, write or atomic add), per-lane write data and the workgroup's base and limit. Each lane address is a dword offset into the workgroup's window. The offset is checked against the limit and then added to the base to form a physical dword address. Bits [4:0] of that physical address select the bank and the bits above select the row.

All lanes that land on different banks are served in the same cycle, so a conflict-free request moves 32 dwords in one pass. Lanes that collide on a bank are served over later passes, lowest lane number first. Reads of one identical dword are merged into a single access. When the last pass has been made, a one-cycle done pulse reports completion. The read data and the per-lane error mask then hold until the next request is accepted.

The full configuration has 1024 rows per bank, which gives 128 kB. A workgroup window is capped at half the array (64 kB). The default parameter set is a reduced depth of 64 rows per bank (8 kB), with the same cap of half the array.

Top module: `lds_top`

## Requirements
- R1: After reset, done is 0, every lane of rdData is 0 and errMask is 0.
- R2: The physical address of a lane is (wgBase + lane offset) modulo the array size. Physical bits [4:0] select the bank, and the bits above them select the row.
- R3: A request is accepted on a rising edge where reqValid is 1 and the block is idle. If it needs P passes, done is 1 for exactly the one cycle that follows the P-th edge after the accepting edge. P is at least 1.
- R4: Lanes whose physical addresses fall in the same bank are served one per pass, lowest lane first. P is the largest number of such accesses in any one bank. Writes by several lanes to one dword therefore leave the highest lane's data.
- R5: For reads, lanes with an identical physical address share one access and add only one to their bank's count.
- R6: The opcode field is 2 bits: 00 read, 01 write, 10 atomic add, 11 read. A read returns the stored dword. A write stores the lane's data and returns 0 in that lane.
- R7: An atomic add stores old+data and returns the old value to its lane. Several lanes that add to one dword are applied in ascending lane order, each lane seeing the sum left by the lanes below it.
- R8: A valid lane whose offset is at or above the effective limit sets its errMask bit. Its write or add is dropped and its rdData lane reads 0.
- R9: The effective limit is the smaller of wgLimit and half the array size (64 kB in the full configuration).
- R10: Lanes whose laneMask bit is 0 read 0, write nothing and raise no error.
- R11: reqValid is ignored while a request is still being served, whatever the other inputs carry.
- R12: done is a single-cycle pulse. rdData and errMask keep their values from completion until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled when idle |
| laneMask | input | NUM_LANES | Lane-valid mask |
| laneAddr | input | NUM_LANES*ADDR_W | Per-lane dword offsets, lane 0 in the low bits |
| opcode | input | 2 | 00 read, 01 write, 10 atomic add, 11 read |
| wrData | input | NUM_LANES*DATA_W | Per-lane write or add data |
| wgBase | input | ADDR_W | Workgroup window base, in dwords |
| wgLimit | input | ADDR_W+1 | Workgroup window size, in dwords |
| rdData | output | NUM_LANES*DATA_W | Per-lane returned data |
| done | output | 1 | One-cycle completion pulse |
| errMask | output | NUM_LANES | Per-lane out-of-range flags |

## Verification
The bench targets several corner cases:

- **Full bank collision.** Stride-32 writes and reads put every lane on one bank and must take exactly 32 passes. A serialiser that dropped or doubled a lane would finish early or late, or lose data.
- **Broadcast and same-address writes.** A broadcast read of one dword must complete in a single pass, which exposes a design that fails to merge identical reads. Same-address writes must leave the highest lane's value, which exposes the wrong service order.
- **Same-address atomic adds.** Atomic adds to one dword must return running sums. A design that merged the adds, or returned the new value, would show wrong per-lane results.
- **Limits and masking.** A small limit, a limit above the half-array cap, masked-off lanes and base wraparound all check that writes are dropped and errors are raised exactly where the window ends.
- **Second request while busy.** A second request is raised while a long request is still running. A design that accepted it would corrupt a region that is read back later.

// File: rtl/lds_pkg.sv
package lds_pkg;

  typedef enum logic [1:0] {
    OP_READ     = 2'b00,
    OP_WRITE    = 2'b01,
    OP_ADD      = 2'b10,
    OP_READ_ALT = 2'b11
  } lds_op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // capture a new request
    logic serve;  // perform one arbitration pass
  } lds_strobe_t;

endpackage

// File: rtl/lds_bank.sv
module lds_bank #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int ROW_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[row] <= wrData;
  end

  assign rdData = mem[row];

endmodule

// File: rtl/lds_ctrl.sv
module lds_ctrl
  import lds_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        passLast,
  output lds_strobe_t strobe,
  output logic        busy,
  output logic        done
);

  typedef enum logic {ST_IDLE, ST_SERVE} ctrl_state_e;

  ctrl_state_e stateQ;

  always_comb begin
    strobe.load  = reqValid && (stateQ == ST_IDLE);
    strobe.serve = (stateQ == ST_SERVE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      done   <= 1'b0;
    end else begin
      done <= strobe.serve && passLast;
      if (strobe.load)                     stateQ <= ST_SERVE;
      else if (strobe.serve && passLast)   stateQ <= ST_IDLE;
    end
  end

  assign busy = (stateQ == ST_SERVE);

endmodule

// File: rtl/lds_datapath.sv
module lds_datapath
  import lds_pkg::*;
#(
  parameter int NUM_LANES  = 32,
  parameter int NUM_BANKS  = 32,
  parameter int BANK_DEPTH = 64,
  parameter int DATA_W     = 32,
  localparam int BANK_W    = $clog2(NUM_BANKS),
  localparam int ROW_W     = $clog2(BANK_DEPTH),
  localparam int ADDR_W    = BANK_W + ROW_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  lds_strobe_t                   strobe,
  input  logic [NUM_LANES-1:0]          laneMask,
  input  logic [NUM_LANES*ADDR_W-1:0]   laneAddr,
  input  logic [1:0]                    opcode,
  input  logic [NUM_LANES*DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]             wgBase,
  input  logic [ADDR_W:0]               wgLimit,
  output logic                          passLast,
  output logic [NUM_LANES*DATA_W-1:0]   rdData,
  output logic [NUM_LANES-1:0]          errMask
);

  localparam int LANE_W = $clog2(NUM_LANES);
  localparam int WIN_DWORDS = (NUM_BANKS * BANK_DEPTH) / 2;
  localparam logic [ADDR_W:0] WIN_LIM = (ADDR_W+1)'(WIN_DWORDS);

  // captured request
  lds_op_e              opQ;
  logic [ADDR_W-1:0]    addrQ [NUM_LANES];
  logic [DATA_W-1:0]    wdQ   [NUM_LANES];
  logic [DATA_W-1:0]    rdQ   [NUM_LANES];
  logic [NUM_LANES-1:0] pendQ;
  logic [NUM_LANES-1:0] errQ;

  // incoming address check
  logic [ADDR_W:0]      effLimit;
  logic [ADDR_W-1:0]    offIn  [NUM_LANES];
  logic [ADDR_W-1:0]    physIn [NUM_LANES];
  logic [NUM_LANES-1:0] inRange;

  always_comb begin
    effLimit = (wgLimit > WIN_LIM) ? WIN_LIM : wgLimit;
    for (int l = 0; l < NUM_LANES; l++) begin
      offIn[l]   = laneAddr[l*ADDR_W +: ADDR_W];
      physIn[l]  = wgBase + offIn[l];
      inRange[l] = ({1'b0, offIn[l]} < effLimit);
    end
  end

  logic isRead, isAdd;
  assign isRead = (opQ == OP_READ) || (opQ == OP_READ_ALT);
  assign isAdd  = (opQ == OP_ADD);

  // per-lane bank index
  logic [BANK_W-1:0] laneBank [NUM_LANES];
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_laneBank
    assign laneBank[l] = addrQ[l][BANK_W-1:0];
  end

  // per-bank arbitration: lowest pending lane wins
  logic              winValid [NUM_BANKS];
  logic [LANE_W-1:0] winLane  [NUM_BANKS];
  logic [ADDR_W-1:0] winAddr  [NUM_BANKS];

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      winValid[b] = 1'b0;
      winLane[b]  = '0;
      for (int l = NUM_LANES - 1; l >= 0; l--) begin
        if (pendQ[l] && (laneBank[l] == BANK_W'(b))) begin
          winValid[b] = 1'b1;
          winLane[b]  = LANE_W'(l);
        end
      end
      winAddr[b] = addrQ[winLane[b]];
    end
  end

  // grant: the winner, plus same-dword readers riding along
  logic [NUM_LANES-1:0] grant;
  always_comb begin
    for (int l = 0; l < NUM_LANES; l++) begin
      grant[l] = pendQ[l] &&
                 ((winLane[laneBank[l]] == LANE_W'(l)) ||
                  (isRead && (addrQ[l] == winAddr[laneBank[l]])));
    end
  end

  assign passLast = ~|(pendQ & ~grant);

  // bank array
  logic [DATA_W-1:0] bankRd [NUM_BANKS];
  logic [DATA_W-1:0] bankWd [NUM_BANKS];
  logic              bankWe [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bankWe[b] = strobe.serve && winValid[b] && !isRead;
    assign bankWd[b] = isAdd ? (bankRd[b] + wdQ[winLane[b]]) : wdQ[winLane[b]];

    lds_bank #(
      .DEPTH (BANK_DEPTH),
      .DATA_W(DATA_W)
    ) u_bank (
      .clk   (clk),
      .we    (bankWe[b]),
      .row   (winAddr[b][ADDR_W-1:BANK_W]),
      .wrData(bankWd[b]),
      .rdData(bankRd[b])
    );
  end

  // request capture and per-pass update
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ   <= OP_READ;
      pendQ <= '0;
      errQ  <= '0;
      for (int l = 0; l < NUM_LANES; l++) begin
        addrQ[l] <= '0;
        wdQ[l]   <= '0;
        rdQ[l]   <= '0;
      end
    end else if (strobe.load) begin
      opQ   <= lds_op_e'(opcode);
      pendQ <= laneMask & inRange;
      errQ  <= laneMask & ~inRange;
      for (int l = 0; l < NUM_LANES; l++) begin
        addrQ[l] <= physIn[l];
        wdQ[l]   <= wrData[l*DATA_W +: DATA_W];
        rdQ[l]   <= '0;
      end
    end else if (strobe.serve) begin
      pendQ <= pendQ & ~grant;
      for (int l = 0; l < NUM_LANES; l++) begin
        if (grant[l] && (opQ != OP_WRITE)) rdQ[l] <= bankRd[laneBank[l]];
      end
    end
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_out
    assign rdData[l*DATA_W +: DATA_W] = rdQ[l];
  end
  assign errMask = errQ;

endmodule

// File: rtl/lds_top.sv
module lds_top
  import lds_pkg::*;
#(
  parameter int NUM_LANES  = 32,
  parameter int NUM_BANKS  = 32,
  parameter int BANK_DEPTH = 64,
  parameter int DATA_W     = 32,
  localparam int ADDR_W    = $clog2(NUM_BANKS) + $clog2(BANK_DEPTH)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [NUM_LANES-1:0]        laneMask,
  input  logic [NUM_LANES*ADDR_W-1:0] laneAddr,
  input  logic [1:0]                  opcode,
  input  logic [NUM_LANES*DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0]           wgBase,
  input  logic [ADDR_W:0]             wgLimit,
  output logic [NUM_LANES*DATA_W-1:0] rdData,
  output logic                        done,
  output logic [NUM_LANES-1:0]        errMask
);

  lds_strobe_t strobe;
  logic        passLast;
  logic        busy;

  lds_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .passLast(passLast),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done)
  );

  lds_datapath #(
    .NUM_LANES (NUM_LANES),
    .NUM_BANKS (NUM_BANKS),
    .BANK_DEPTH(BANK_DEPTH),
    .DATA_W    (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .laneMask(laneMask),
    .laneAddr(laneAddr),
    .opcode  (opcode),
    .wrData  (wrData),
    .wgBase  (wgBase),
    .wgLimit (wgLimit),
    .passLast(passLast),
    .rdData  (rdData),
    .errMask (errMask)
  );

endmodule

// File: rtl/lds_checker.sv
module lds_checker #(
  parameter int NUM_LANES = 32,
  parameter int DATA_W    = 32
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        reqValid,
  input logic                        busy,
  input logic                        done,
  input logic [NUM_LANES-1:0]        errMask,
  input logic [NUM_LANES*DATA_W-1:0] rdData
);

  logic [NUM_LANES-1:0] laneNz;
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_nz
    assign laneNz[l] = |rdData[l*DATA_W +: DATA_W];
  end

  // R12: completion is a single-cycle pulse
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: done follows a serving cycle and leaves the block idle
  assert_done_after_serve_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R11: serving only starts from a request seen while idle
  assert_busy_needs_req_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

  // R8: an errored lane never returns data
  assert_err_lane_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (errMask & laneNz) == '0);

  // R12: error flags change only after an accepted request
  assert_err_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !$past(reqValid && !busy) |-> $stable(errMask));

endmodule

bind lds_top lds_checker #(
  .NUM_LANES(NUM_LANES),
  .DATA_W   (DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqValid(reqValid),
  .busy    (busy),
  .done    (done),
  .errMask (errMask),
  .rdData  (rdData)
);

// File: tb/lds_top_tb.sv
`timescale 1ns/1ps
module lds_top_tb;

  localparam int NL = 32;
  localparam int DW = 32;
  localparam int AW = 11;
  localparam int SIZE = 2048;
  localparam int WIN = 1024;

  typedef struct packed {
    logic [1:0]  op;
    logic [5:0]  stride;
    logic [10:0] start;
    logic [10:0] base;
    logic [11:0] limit;
    logic [31:0] mask;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 6'd1,  11'd0,    11'd0,    12'd1024, 32'hFFFFFFFF, 4'd6},
    '{2'd0, 6'd1,  11'd0,    11'd0,    12'd1024, 32'hFFFFFFFF, 4'd3},
    '{2'd1, 6'd32, 11'd0,    11'd100,  12'd1024, 32'hFFFFFFFF, 4'd4},
    '{2'd0, 6'd32, 11'd0,    11'd100,  12'd1024, 32'hFFFFFFFF, 4'd4},
    '{2'd0, 6'd0,  11'd5,    11'd0,    12'd1024, 32'hFFFFFFFF, 4'd5},
    '{2'd1, 6'd0,  11'd7,    11'd0,    12'd1024, 32'hFFFFFFFF, 4'd4},
    '{2'd0, 6'd0,  11'd7,    11'd0,    12'd1024, 32'hFFFFFFFF, 4'd5},
    '{2'd2, 6'd0,  11'd9,    11'd0,    12'd1024, 32'hFFFFFFFF, 4'd7},
    '{2'd0, 6'd0,  11'd9,    11'd0,    12'd1024, 32'hFFFFFFFF, 4'd7},
    '{2'd2, 6'd1,  11'd0,    11'd0,    12'd1024, 32'hFFFFFFFF, 4'd7},
    '{2'd1, 6'd1,  11'd0,    11'd512,  12'd8,    32'hFFFFFFFF, 4'd8},
    '{2'd0, 6'd1,  11'd0,    11'd512,  12'd1024, 32'hFFFFFFFF, 4'd8},
    '{2'd0, 6'd1,  11'd1000, 11'd0,    12'd2047, 32'hFFFFFFFF, 4'd9},
    '{2'd1, 6'd2,  11'd3,    11'd0,    12'd1024, 32'h0000FFFF, 4'd10},
    '{2'd3, 6'd1,  11'd0,    11'd0,    12'd1024, 32'hA5A5A5A5, 4'd10},
    '{2'd1, 6'd16, 11'd0,    11'd7,    12'd1024, 32'hFFFFFFFF, 4'd2},
    '{2'd0, 6'd16, 11'd0,    11'd7,    12'd1024, 32'hFFFFFFFF, 4'd2},
    '{2'd0, 6'd1,  11'd0,    11'd2040, 12'd64,   32'hFFFFFFFF, 4'd2}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [NL-1:0]     laneMask = '0;
  logic [NL*AW-1:0]  laneAddr = '0;
  logic [1:0]        opcode = 2'b00;
  logic [NL*DW-1:0]  wrData = '0;
  logic [AW-1:0]     wgBase = '0;
  logic [AW:0]       wgLimit = '0;
  logic [NL*DW-1:0]  rdData;
  logic              done;
  logic [NL-1:0]     errMask;

  lds_top u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .laneMask(laneMask),
    .laneAddr(laneAddr), .opcode(opcode), .wrData(wrData), .wgBase(wgBase),
    .wgLimit(wgLimit), .rdData(rdData), .done(done), .errMask(errMask)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic [31:0] refMem [SIZE];
  logic [NL*DW-1:0] lastRd;
  logic [NL-1:0] lastErr;

  function automatic string reqName(input logic [3:0] n);
    case (n)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic checkVal(input bit ok, input string what, input longint got, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", what, got, exp);
    end
  endtask

  task automatic checkRd(input logic [NL*DW-1:0] exp, input string what);
    checks++;
    if (rdData !== exp) begin
      fails++;
      for (int l = 0; l < NL; l++) begin
        if (rdData[l*DW +: DW] !== exp[l*DW +: DW]) begin
          $display("FAIL %s lane %0d: got %0h expected %0h", what, l,
                   rdData[l*DW +: DW], exp[l*DW +: DW]);
          break;
        end
      end
    end
  endtask

  task automatic doReq(input vec_t v, input int seed, input bit inject, input string tag);
    logic [NL*DW-1:0] expRd;
    logic [NL-1:0]    expErr;
    int bankCnt [32];
    int phys [NL];
    bit act [NL];
    int passes, eff, off, cnt;
    bit got, rd;
    logic [31:0] wd;
    expRd = '0;
    expErr = '0;
    rd = (v.op == 2'd0) || (v.op == 2'd3);
    eff = (int'(v.limit) > WIN) ? WIN : int'(v.limit);
    for (int b = 0; b < 32; b++) bankCnt[b] = 0;
    for (int l = 0; l < NL; l++) begin
      off = int'(v.start) + l * int'(v.stride);
      laneAddr[l*AW +: AW] = AW'(off);
      wrData[l*DW +: DW] = 32'(seed) * 32'h10000 + 32'(l * 5 + 3);
      act[l] = 1'b0;
      phys[l] = 0;
      if (v.mask[l]) begin
        if (off >= eff) expErr[l] = 1'b1;
        else begin
          act[l] = 1'b1;
          phys[l] = (int'(v.base) + off) % SIZE;
        end
      end
    end
    for (int l = 0; l < NL; l++) begin
      if (act[l]) begin
        bit first;
        first = 1'b1;
        if (rd) for (int k = 0; k < l; k++) if (act[k] && phys[k] == phys[l]) first = 1'b0;
        if (first) bankCnt[phys[l] % 32]++;
        wd = wrData[l*DW +: DW];
        case (v.op)
          2'd1: refMem[phys[l]] = wd;
          2'd2: begin
            expRd[l*DW +: DW] = refMem[phys[l]];
            refMem[phys[l]] = refMem[phys[l]] + wd;
          end
          default: expRd[l*DW +: DW] = refMem[phys[l]];
        endcase
      end
    end
    passes = 1;
    for (int b = 0; b < 32; b++) if (bankCnt[b] > passes) passes = bankCnt[b];

    laneMask = v.mask;
    opcode = v.op;
    wgBase = v.base;
    wgLimit = v.limit;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    cnt = 0;
    got = 1'b0;
    while (!got && cnt < 200) begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      if (inject && cnt == 2) begin
        // R11: request raised mid-service, must be ignored
        reqValid = 1'b1;
        opcode = 2'b01;
        laneMask = '1;
        wgBase = 11'd1500;
        wgLimit = 12'd1024;
        for (int l = 0; l < NL; l++) begin
          laneAddr[l*AW +: AW] = AW'(l);
          wrData[l*DW +: DW] = 32'hDEAD0000 + 32'(l);
        end
      end else reqValid = 1'b0;
      if (done) got = 1'b1;
    end
    reqValid = 1'b0;
    checkVal(cnt == passes, $sformatf("R3/R4 pass count (%s)", tag), cnt, passes);
    checkRd(expRd, $sformatf("R6 lane data (%s)", tag));
    checkVal(errMask === expErr, $sformatf("R8 error mask (%s)", tag), errMask, expErr);
    @(posedge clk);
    @(negedge clk);
    checkVal(done === 1'b0, $sformatf("R12 done pulse width (%s)", tag), done, 0);
    lastRd = expRd;
    lastErr = expErr;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    vec_t v;
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    checkVal(done === 1'b0, "R1 done after reset", done, 0);
    checkVal(rdData === '0, "R1 rdData after reset", 0, 0);
    checkVal(errMask === '0, "R1 errMask after reset", errMask, 0);
    rstN = 1'b1;
    @(negedge clk);

    // fill the whole array with known data
    for (int k = 0; k < SIZE / 32; k++) begin
      v = '{2'd1, 6'd1, 11'd0, 11'(k * 32), 12'd1024, 32'hFFFFFFFF, 4'd6};
      doReq(v, 100 + k, 1'b0, "R6 fill");
    end

    // table walk
    for (int i = 0; i < NVEC; i++) doReq(VECS[i], i + 1, 1'b0, reqName(VECS[i].req));

    // R11: long request with a second request raised mid-service
    v = '{2'd1, 6'd32, 11'd0, 11'd64, 12'd1024, 32'hFFFFFFFF, 4'd4};
    doReq(v, 50, 1'b1, "R11 busy");
    v = '{2'd0, 6'd1, 11'd0, 11'd1500, 12'd1024, 32'hFFFFFFFF, 4'd6};
    doReq(v, 51, 1'b0, "R11 untouched");

    // R10: empty mask still completes in one pass
    v = '{2'd0, 6'd1, 11'd0, 11'd0, 12'd1024, 32'h00000000, 4'd10};
    doReq(v, 52, 1'b0, "R10 empty");

    // R12: results hold while idle
    v = '{2'd0, 6'd1, 11'd2000, 11'd0, 12'd1024, 32'hFFFFFFFF, 4'd9};
    doReq(v, 53, 1'b0, "R12 setup");
    repeat (10) @(posedge clk);
    @(negedge clk);
    checkRd(lastRd, "R12 rdData hold");
    checkVal(errMask === lastErr, "R12 errMask hold", errMask, lastErr);
    checkVal(done === 1'b0, "R12 done idle", done, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule